// File: doc/BRIEF.md
# Two-Wire Bus Clock Waveform Generator

This block produces the serial clock for a two-wire bus master from the peripheral clock. A 32-bit waveform word supplies the timing. It holds separate 8-bit dividers for the low and the high phase of SCL, a shared power-of-two prescale exponent, and a 5-bit field for the SDA hold time. A phase lasts `(divider << prescale) + OFFSET` peripheral clocks. `OFFSET` is a fixed parameter, normally 3 or 4. If the two dividers are equal, the bus runs at Fclk / (2 × phase length).

The master raises `xfer_active` to request clock activity. The generator reports its progress through three single-cycle ticks:
- `sda_change_tick` marks the cycle inside each low phase at which SDA may be changed, which is the hold field plus 3 cycles after SCL fell.
- `low_end_tick` marks the last cycle of the low phase.
- `high_end_tick` marks the last cycle of the high phase.

After releasing SCL, the generator does not count the high phase until the sampled line `scl_in` reads high. A slave that holds SCL low therefore stretches the clock.

The controller has four states:
- **IDLE**: SCL is released and no ticks are produced.
- **LOW**: SCL is driven low and the low phase is counted.
- **WAIT_HIGH**: SCL is released and the generator waits for the line to read high.
- **HIGH**: the high phase is counted.

The transitions are:
- **START** (IDLE→LOW): taken when `xfer_active` is high. The waveform word is captured on this transition.
- **RELEASE** (LOW→WAIT_HIGH): taken on the last low cycle.
- **LINE_HIGH** (WAIT_HIGH→HIGH): taken when `scl_in` reads high.
- **NEXT_BIT** (HIGH→LOW): taken on the last high cycle if `xfer_active` is still high.
- **STOP** (HIGH→IDLE): taken on the last high cycle if `xfer_active` is low.

Top module: `cwg_clock_gen`

## Requirements
- R1: After reset, and whenever the controller is idle, `scl_drive_low` is 0 and none of the three ticks is asserted.
- R2: Each low phase lasts `(word[7:0] << p) + OFFSET` cycles, where `p` is the effective prescale exponent. SCL is driven low for exactly that many cycles, and `low_end_tick` is high in the last of them.
- R3: The high phase ends after `(word[15:8] << p) + OFFSET` cycles, counted from the first cycle in which `scl_in` is sampled high after release. `high_end_tick` is high in the last of those cycles.
- R4: While `scl_in` reads low after release, the high count does not advance. Each stretched cycle delays `high_end_tick` by exactly one cycle.
- R5: The low-phase cycles are numbered from 0. `sda_change_tick` pulses once per low phase, in the cycle whose index equals `word[28:24] + 3`.
- R6: If `word[28:24] + 3` is not below the low length, `sda_change_tick` moves to the last low cycle, together with `low_end_tick`.
- R7: The prescale field `word[18:16]` is clamped to the parameter `MAX_PRE`. Larger values time the clock exactly as `MAX_PRE` does.
- R8: `xfer_active` is sampled only at IDLE and in the last high cycle. If it is low at that point, the controller returns to IDLE with SCL released. Dropping it earlier does not shorten the current bit.
- R9: The waveform word is captured on START. Changes to it during a transfer have no effect until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_active | input | 1 | The master requests clock activity |
| cwg_word | input | 32 | Waveform word: low divider 7:0, high divider 15:8, prescale 18:16, hold 28:24, other bits zero |
| scl_in | input | 1 | Sampled level of the SCL line |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_change_tick | output | 1 | The SDA hold time has elapsed in this low phase |
| low_end_tick | output | 1 | Last cycle of the low phase |
| high_end_tick | output | 1 | Last cycle of the high phase |

## Verification
The assertions assume the following about the inputs:
- `scl_in` is already synchronised to `clk`.
- `scl_in` cannot read high while the block itself drives SCL low.
- The reserved bits of the waveform word are zero whenever a transfer starts.

The bench models the wired bus. It forms `scl_in` as the AND of the released line and a slave-stretch counter, so the line only ever reads high while released. Every waveform word the bench builds leaves the reserved bits clear, even the word it changes in the middle of a transfer.

// File: rtl/cwg_pkg.sv
package cwg_pkg;

    localparam int DIV_W      = 8;
    localparam int PRE_W      = 3;
    localparam int HOLD_W     = 5;
    localparam int LO_LSB     = 0;
    localparam int HI_LSB     = 8;
    localparam int PRE_LSB    = 16;
    localparam int HOLD_LSB   = 24;
    localparam int HOLD_FLOOR = 3;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_LOW       = 2'd1,
        ST_WAIT_HIGH = 2'd2,
        ST_HIGH      = 2'd3
    } cwg_state_e;

    typedef enum logic [1:0] {
        CNT_KEEP  = 2'd0,
        CNT_CLEAR = 2'd1,
        CNT_ONE   = 2'd2,
        CNT_STEP  = 2'd3
    } cnt_op_e;

    typedef struct packed {
        logic [DIV_W-1:0]  lo_div;
        logic [DIV_W-1:0]  hi_div;
        logic [PRE_W-1:0]  pre;
        logic [HOLD_W-1:0] hold;
    } cwg_cfg_t;

    function automatic cwg_cfg_t unpack_word(input logic [31:0] w,
                                             input logic [PRE_W-1:0] pre_cap);
        cwg_cfg_t c;
        logic [PRE_W-1:0] p;
        p        = w[PRE_LSB +: PRE_W];
        c.lo_div = w[LO_LSB +: DIV_W];
        c.hi_div = w[HI_LSB +: DIV_W];
        c.pre    = (p > pre_cap) ? pre_cap : p;
        c.hold   = w[HOLD_LSB +: HOLD_W];
        return c;
    endfunction

endpackage

// File: rtl/cwg_cfg_shadow.sv
module cwg_cfg_shadow
    import cwg_pkg::*;
#(
    parameter int OFFSET  = 3,
    parameter int MAX_PRE = 5,
    parameter int LEN_W   = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [31:0]      word,
    output logic [LEN_W-1:0] low_len,
    output logic [LEN_W-1:0] high_len,
    output logic [LEN_W-1:0] sda_point
);

    localparam logic [PRE_W-1:0] PRE_CAP = PRE_W'(MAX_PRE);
    localparam int               NPHASE  = 2;

    cwg_cfg_t                     shadow;
    logic [NPHASE-1:0][DIV_W-1:0] divs;
    logic [NPHASE-1:0][LEN_W-1:0] lens;
    logic [LEN_W-1:0]             hold_pt;
    logic [LEN_W-1:0]             last_low;
    logic [31:0]                  rsvd_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow <= '0;
        end else if (load) begin
            shadow <= unpack_word(word, PRE_CAP);
        end
    end

    assign divs[0] = shadow.lo_div;
    assign divs[1] = shadow.hi_div;

    for (genvar g = 0; g < NPHASE; g++) begin : g_phase_len
        assign lens[g] = (LEN_W'(divs[g]) << shadow.pre) + LEN_W'(OFFSET);
    end

    assign low_len   = lens[0];
    assign high_len  = lens[1];
    assign last_low  = low_len - LEN_W'(1);
    assign hold_pt   = LEN_W'(shadow.hold) + LEN_W'(HOLD_FLOOR);
    assign sda_point = (hold_pt < last_low) ? hold_pt : last_low;

    assign rsvd_mask = ~((32'((1 << DIV_W) - 1) << LO_LSB)
                       | (32'((1 << DIV_W) - 1) << HI_LSB)
                       | (32'((1 << PRE_W) - 1) << PRE_LSB)
                       | (32'((1 << HOLD_W) - 1) << HOLD_LSB));

    AST_PRE_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        shadow.pre <= PRE_CAP); // R7
    AST_SDA_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        sda_point < low_len); // R6
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> ((word & rsvd_mask) == 32'd0)); // R9
    AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(low_len) && $stable(high_len)); // R9

endmodule

// File: rtl/cwg_phase_counter.sv
module cwg_phase_counter
    import cwg_pkg::*;
#(
    parameter int LEN_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cnt_op_e          op,
    output logic [LEN_W-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case (op)
                CNT_KEEP:  count <= count;
                CNT_CLEAR: count <= '0;
                CNT_ONE:   count <= LEN_W'(1);
                CNT_STEP:  count <= count + LEN_W'(1);
                default:   count <= count;
            endcase
        end
    end

    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == CNT_CLEAR) |=> (count == '0)); // R2

endmodule

// File: rtl/cwg_phase_fsm.sv
module cwg_phase_fsm
    import cwg_pkg::*;
#(
    parameter int LEN_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_active,
    input  logic             scl_in,
    input  logic [LEN_W-1:0] cnt,
    input  logic [LEN_W-1:0] low_len,
    input  logic [LEN_W-1:0] high_len,
    input  logic [LEN_W-1:0] sda_point,
    output cnt_op_e          cnt_op,
    output logic             load_cfg,
    output logic             scl_drive_low,
    output logic             sda_change_tick,
    output logic             low_end_tick,
    output logic             high_end_tick
);

    cwg_state_e state;
    cwg_state_e state_nx;
    logic       low_last;
    logic       high_last;

    assign low_last  = (cnt == low_len - LEN_W'(1));
    assign high_last = (cnt == high_len - LEN_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (xfer_active) state_nx = ST_LOW;
            ST_LOW:       if (low_last)    state_nx = ST_WAIT_HIGH;
            ST_WAIT_HIGH: if (scl_in)      state_nx = ST_HIGH;
            ST_HIGH: begin
                if (high_last) begin
                    state_nx = xfer_active ? ST_LOW : ST_IDLE;
                end
            end
            default:      state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        cnt_op          = CNT_KEEP;
        load_cfg        = 1'b0;
        scl_drive_low   = 1'b0;
        sda_change_tick = 1'b0;
        low_end_tick    = 1'b0;
        high_end_tick   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (xfer_active) begin
                    cnt_op   = CNT_CLEAR;
                    load_cfg = 1'b1;
                end
            end
            ST_LOW: begin
                scl_drive_low   = 1'b1;
                sda_change_tick = (cnt == sda_point);
                low_end_tick    = low_last;
                cnt_op          = low_last ? CNT_CLEAR : CNT_STEP;
            end
            ST_WAIT_HIGH: begin
                cnt_op = scl_in ? CNT_ONE : CNT_KEEP;
            end
            ST_HIGH: begin
                high_end_tick = high_last;
                cnt_op        = high_last ? CNT_CLEAR : CNT_STEP;
            end
            default: cnt_op = CNT_CLEAR;
        endcase
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !scl_drive_low && !sda_change_tick
                               && !low_end_tick && !high_end_tick); // R1
    AST_RELEASE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        low_end_tick |=> !scl_drive_low); // R2
    AST_HIGH_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        high_end_tick |-> $past(scl_in)); // R4
    AST_SDA_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        sda_change_tick |-> scl_drive_low); // R5
    AST_SDA_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        sda_change_tick |=> !sda_change_tick); // R5
    AST_STOP_AT_HIGH_END: assert property (@(posedge clk) disable iff (!rst_n)
        (high_end_tick && !xfer_active) |=> (state == ST_IDLE)); // R8
    AST_GO_ON_AT_HIGH_END: assert property (@(posedge clk) disable iff (!rst_n)
        (high_end_tick && xfer_active) |=> scl_drive_low); // R8

endmodule

// File: rtl/cwg_clock_gen.sv
module cwg_clock_gen
    import cwg_pkg::*;
#(
    parameter int OFFSET  = 3,
    parameter int MAX_PRE = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        xfer_active,
    input  logic [31:0] cwg_word,
    input  logic        scl_in,
    output logic        scl_drive_low,
    output logic        sda_change_tick,
    output logic        low_end_tick,
    output logic        high_end_tick
);

    localparam int LEN_W = DIV_W + MAX_PRE + 1;

    logic [LEN_W-1:0] low_len;
    logic [LEN_W-1:0] high_len;
    logic [LEN_W-1:0] sda_point;
    logic [LEN_W-1:0] cnt;
    logic             load_cfg;
    cnt_op_e          cnt_op;

    cwg_cfg_shadow #(
        .OFFSET  (OFFSET),
        .MAX_PRE (MAX_PRE),
        .LEN_W   (LEN_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_cfg),
        .word      (cwg_word),
        .low_len   (low_len),
        .high_len  (high_len),
        .sda_point (sda_point)
    );

    cwg_phase_counter #(
        .LEN_W (LEN_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (cnt_op),
        .count (cnt)
    );

    cwg_phase_fsm #(
        .LEN_W (LEN_W)
    ) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .xfer_active     (xfer_active),
        .scl_in          (scl_in),
        .cnt             (cnt),
        .low_len         (low_len),
        .high_len        (high_len),
        .sda_point       (sda_point),
        .cnt_op          (cnt_op),
        .load_cfg        (load_cfg),
        .scl_drive_low   (scl_drive_low),
        .sda_change_tick (sda_change_tick),
        .low_end_tick    (low_end_tick),
        .high_end_tick   (high_end_tick)
    );

    AST_LOW_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        scl_drive_low |-> (cnt < low_len)); // R2
    AST_HIGH_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        high_end_tick |-> (cnt < high_len)); // R3

endmodule

// File: tb/cwg_clock_gen_bench.sv
module cwg_clock_gen_bench;

    localparam int OFF  = 3;
    localparam int MAXP = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_active = 1'b0;
    logic [31:0] cwg_word = 32'd0;
    logic        scl_in;
    logic        scl_drive_low;
    logic        sda_change_tick;
    logic        low_end_tick;
    logic        high_end_tick;

    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    int    stretch_len = 0;
    int    scnt = 0;
    bit    done = 1'b0;
    string cur_req = "R1";
    int    q_kind[$];
    int    q_cyc[$];

    always #2.5 clk = ~clk;

    cwg_clock_gen #(.OFFSET(OFF), .MAX_PRE(MAXP)) u_cwg_clock_gen (
        .clk             (clk),
        .rst_n           (rst_n),
        .xfer_active     (xfer_active),
        .cwg_word        (cwg_word),
        .scl_in          (scl_in),
        .scl_drive_low   (scl_drive_low),
        .sda_change_tick (sda_change_tick),
        .low_end_tick    (low_end_tick),
        .high_end_tick   (high_end_tick)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        if (!rst_n)              scnt <= 0;
        else if (scl_drive_low)  scnt <= stretch_len;
        else if (scnt != 0)      scnt <= scnt - 1;
    end
    assign scl_in = !scl_drive_low && (scnt == 0);

    function automatic logic [31:0] mk(int lo, int hi, int pre, int hold);
        return {3'b000, 5'(hold), 5'b00000, 3'(pre), 8'(hi), 8'(lo)};
    endfunction

    function automatic int plen(int div, int pre);
        int p;
        p = (pre > MAXP) ? MAXP : pre;
        return (div << p) + OFF;
    endfunction

    task automatic pop_check(int kind);
        int ek;
        int ec;
        checks++;
        if (q_kind.size() == 0) begin
            fails++;
            $display("FAIL %s unexpected tick kind=%0d at cycle %0d, expected none",
                     cur_req, kind, cyc);
        end else begin
            ek = q_kind.pop_front();
            ec = q_cyc.pop_front();
            if (ek != kind || ec != cyc) begin
                fails++;
                $display("FAIL %s tick actual kind=%0d cycle=%0d expected kind=%0d cycle=%0d",
                         cur_req, kind, cyc, ek, ec);
            end
        end
    endtask

    // Monitor: scoreboard side, kinds 0=sda point, 1=low end, 2=high end
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (sda_change_tick) pop_check(0);
            if (low_end_tick)    pop_check(1);
            if (high_end_tick)   pop_check(2);
        end
    end

    task automatic check_idle(string req);
        checks++;
        if (scl_drive_low || sda_change_tick || low_end_tick || high_end_tick) begin
            fails++;
            $display("FAIL %s idle outputs actual=%b%b%b%b expected=0000",
                     req, scl_drive_low, sda_change_tick, low_end_tick, high_end_tick);
        end
    endtask

    // Driver: pushes expected ticks, then runs the transfer
    task automatic run_xfer(string req, logic [31:0] word, int nbits, int stretch,
                            bit chg, logic [31:0] new_word);
        int lo_l;
        int hi_l;
        int hp;
        int c0;
        int c_first;
        int last_start;
        lo_l = plen(int'(word[7:0]), int'(word[18:16]));
        hi_l = plen(int'(word[15:8]), int'(word[18:16]));
        hp   = int'(word[28:24]) + 3;
        if (hp > lo_l - 1) hp = lo_l - 1;
        @(negedge clk);
        cur_req     = req;
        stretch_len = stretch;
        cwg_word    = word;
        xfer_active = 1'b1;
        c0          = cyc + 1;
        c_first     = c0;
        last_start  = c0;
        for (int b = 0; b < nbits; b++) begin
            q_kind.push_back(0); q_cyc.push_back(c0 + hp);
            q_kind.push_back(1); q_cyc.push_back(c0 + lo_l - 1);
            q_kind.push_back(2); q_cyc.push_back(c0 + lo_l + stretch + hi_l - 1);
            last_start = c0;
            c0 = c0 + lo_l + stretch + hi_l;
        end
        while (cyc < last_start) begin
            @(negedge clk);
            if (chg && cyc == c_first + 2) cwg_word = new_word;
        end
        xfer_active = 1'b0;
        while (q_kind.size() != 0) @(negedge clk);
        @(negedge clk);
        check_idle("R8");
        @(negedge clk);
        check_idle("R1");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R1");
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check_idle("R1");
        end
        // R2 R3 R5: basic, low 5 high 6, sda point 3
        run_xfer("R2", mk(2, 3, 0, 0), 3, 0, 1'b0, 32'd0);
        // R5: hold 5 inside a 13-cycle low phase, point 8
        run_xfer("R5", mk(10, 4, 0, 5), 2, 0, 1'b0, 32'd0);
        // R3: prescale 2, low 7 high 11
        run_xfer("R3", mk(1, 2, 2, 1), 2, 0, 1'b0, 32'd0);
        // R4: slave stretches every high phase by 4 cycles
        run_xfer("R4", mk(2, 3, 0, 0), 3, 4, 1'b0, 32'd0);
        // R6: hold 31 in a 3-cycle low phase clamps to last low cycle
        run_xfer("R6", mk(0, 0, 0, 31), 3, 0, 1'b0, 32'd0);
        // R7: prescale field 7 behaves as MAXP
        run_xfer("R7", mk(1, 1, 7, 2), 2, 0, 1'b0, 32'd0);
        // R9: word changed mid-transfer is ignored
        run_xfer("R9", mk(3, 2, 1, 2), 3, 0, 1'b1, mk(9, 9, 3, 0));
        // R8: single bit, active dropped during the low phase
        run_xfer("R8", mk(4, 1, 0, 0), 1, 2, 1'b0, 32'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL %s watchdog actual=hung expected=finished", cur_req);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule